// File: doc/BRIEF.md
# Reset-Aware Boot Mode Selector

This block decides, for a six-core processor, which boot mode applies after each kind of reset. Three device-level causes arrive as synchronous active-high levels: power-on, warm and system. While power-on or warm reset is asserted, the block copies a 4-bit external strap value into a stored device mode field. A system reset leaves that field untouched, so the mode after a system reset is the one latched by the last power-on or warm reset, whatever the pins show. When any device-level reset is released, the block emits a one-cycle device start pulse, and the stored field is presented as the device boot mode.

Each core also owns a one-bit mode register, where 0 means immediate boot and 1 means host boot. Software sets it through a simple register port. Any device-level reset clears all six registers back to immediate. A core's local reset may come from its external pin, from the on-chip reset controller or from the power-sleep controller, and the three are combined. When a core's local reset is released, the block pulses that core's start output for one cycle and presents that core's stored mode on its host output. A device-level reset overrides any local reset that overlaps it.

Top module: `boot_mode_sel`

## Requirements
- R1: After the asynchronous block reset is released, every output is 0 and reading address 6 returns 0.
- R2: On every clock edge at which power-on or warm reset is high, the stored device mode field takes the strap value. The field is shown on dev_mode_o and is read at address 6 in bits [3:0].
- R3: While only the system reset is high, the stored device mode field keeps its value, and strap changes have no effect on it.
- R4: dev_start_o is high for exactly one cycle. It rises at the first clock edge at which no device-level reset is high, provided one was high at the previous edge.
- R5: A write to address i (0 to 5) stores reg_wdata_i in core i's mode register. A read of address i returns that bit in bit 0, with zeros above it. 0 means immediate and 1 means host.
- R6: Register writes are ignored while any device-level reset is high. A write to address 6 or 7 changes no register.
- R7: Any device-level reset clears all six core mode registers to 0 (immediate).
- R8: A core's local reset may come from its pin, controller or sleep-controller input. At the first edge at which that reset is low after being high, core_start_o[i] goes high for one cycle and core_host_o[i] takes the core's mode register value, which it then holds.
- R9: A device-level reset takes priority over local resets. A local reset that overlaps a device-level reset and is released together with it produces no core start pulse, and no core start pulse follows an edge at which a device-level reset is high.
- R10: When a write to core i's register falls on the same edge as that core's local-reset release, core_host_o[i] takes the value stored before the write, and the register holds the new value afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low block reset, released synchronously inside |
| strap_i | input | 4 | External boot mode strap value |
| por_i | input | 1 | Power-on reset request, active high |
| warm_i | input | 1 | Warm device reset request, active high |
| sys_i | input | 1 | System reset request (watchdog or debugger), active high |
| lrst_pin_i | input | 6 | Per-core external local reset, active high |
| lrst_ctl_i | input | 6 | Per-core local reset from the reset controller, active high |
| lrst_psc_i | input | 6 | Per-core local reset from the power-sleep controller, active high |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address: 0 to 5 for the cores, 6 for the device mode field |
| reg_wdata_i | input | 1 | Write data (core mode bit) |
| reg_rdata_o | output | 4 | Combinational read data for reg_addr_i |
| dev_start_o | output | 1 | One-cycle pulse on device-level reset release |
| dev_mode_o | output | 4 | Resolved device boot mode |
| core_start_o | output | 6 | Per-core one-cycle pulse on local reset release |
| core_host_o | output | 6 | Per-core resolved mode of the last local boot (1 = host) |

## Verification
Two operations can land on the same edge: a software write to a core's mode register and the release of that core's local reset. The bench drops a core's local reset and writes the opposite value to that core's register on the same edge. It then requires the start pulse to carry the value stored before the write, and a read-back afterwards to show the new value. A second coincidence is a local reset overlapping a device-level reset, with both released on the same edge. For that case the bench expects the device start pulse, no core pulse, and cleared core registers.

// File: rtl/boot_sel_pkg.sv
package boot_sel_pkg;

  typedef struct packed {
    logic por;
    logic warm;
    logic sys;
  } dev_cause_t;

  typedef enum logic {
    BOOT_IMMEDIATE = 1'b0,
    BOOT_HOST      = 1'b1
  } core_boot_e;

endpackage

// File: rtl/rst_sync.sv
module rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = sync_q[STAGES-1];

endmodule

// File: rtl/dev_mode_unit.sv
module dev_mode_unit
  import boot_sel_pkg::*;
#(
  parameter int MODE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  dev_cause_t        cause_i,
  input  logic [MODE_W-1:0] strap_i,
  output logic              dev_rst_o,
  output logic [MODE_W-1:0] mode_o,
  output logic              start_o
);

  logic              load_en;
  logic              dev_rst;
  logic [MODE_W-1:0] stat_q, stat_d;
  logic              inrst_q, inrst_d;
  logic              start_q, start_d;

  always_comb begin
    load_en = cause_i.por | cause_i.warm;
    dev_rst = load_en | cause_i.sys;
    stat_d  = strap_i;
    inrst_d = dev_rst;
    start_d = inrst_q & ~dev_rst;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q  <= '0;
      inrst_q <= 1'b0;
      start_q <= 1'b0;
    end else begin
      if (load_en) stat_q <= stat_d;
      inrst_q <= inrst_d;
      start_q <= start_d;
    end
  end

  assign dev_rst_o = dev_rst;
  assign mode_o    = stat_q;
  assign start_o   = start_q;

  AST_STAT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (cause_i.por | cause_i.warm) |=> (mode_o == $past(strap_i))); // R2
  AST_STAT_HOLD_SYS: assert property (@(posedge clk) disable iff (!rst_n)
    (cause_i.sys & ~cause_i.por & ~cause_i.warm) |=> $stable(mode_o)); // R3
  AST_DEV_PULSE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |=> !start_o); // R4

endmodule

// File: rtl/core_mode_regs.sv
module core_mode_regs #(
  parameter int NCORE  = 6,
  parameter int ADDR_W = 3,
  parameter int MODE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dev_rst_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wdata_i,
  input  logic [MODE_W-1:0] stat_i,
  output logic [NCORE-1:0]  mode_o,
  output logic [MODE_W-1:0] rdata_o
);

  localparam int STAT_ADDR = NCORE;

  logic [NCORE-1:0] mode_q;

  for (genvar gi = 0; gi < NCORE; gi++) begin : g_reg
    logic hit;
    logic en;
    logic nxt;

    always_comb begin
      hit = wr_i && (int'(addr_i) == gi);
      en  = dev_rst_i | hit;
      nxt = dev_rst_i ? 1'b0 : wdata_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  mode_q[gi] <= 1'b0;
      else if (en) mode_q[gi] <= nxt;
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NCORE; i++) begin
      if (int'(addr_i) == i) rdata_o = {{(MODE_W-1){1'b0}}, mode_q[i]};
    end
    if (int'(addr_i) == STAT_ADDR) rdata_o = stat_i;
  end

  assign mode_o = mode_q;

  AST_CLR_ON_DEVRST: assert property (@(posedge clk) disable iff (!rst_n)
    dev_rst_i |=> (mode_o == '0)); // R7

endmodule

// File: rtl/core_boot_ctl.sv
module core_boot_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic dev_rst_i,
  input  logic lrst_i,
  input  logic mode_i,
  output logic start_o,
  output logic host_o
);

  logic crst_q, crst_d;
  logic start_q, start_d;
  logic host_q, host_d;
  logic release_now;

  always_comb begin
    crst_d      = dev_rst_i ? 1'b0 : lrst_i;
    release_now = crst_q & ~lrst_i & ~dev_rst_i;
    start_d     = release_now;
    host_d      = mode_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crst_q  <= 1'b0;
      start_q <= 1'b0;
      host_q  <= 1'b0;
    end else begin
      crst_q  <= crst_d;
      start_q <= start_d;
      if (release_now) host_q <= host_d;
    end
  end

  assign start_o = start_q;
  assign host_o  = host_q;

  AST_CORE_PULSE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |=> !start_o); // R8
  AST_NO_CORE_IN_DEV: assert property (@(posedge clk) disable iff (!rst_n)
    dev_rst_i |=> !start_o); // R9
  AST_HOST_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(start_o) |-> (host_o == $past(mode_i))); // R10

endmodule

// File: rtl/boot_mode_sel.sv
module boot_mode_sel
  import boot_sel_pkg::*;
#(
  parameter int NCORE  = 6,
  parameter int MODE_W = 4,
  localparam int ADDR_W = $clog2(NCORE + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] strap_i,
  input  logic              por_i,
  input  logic              warm_i,
  input  logic              sys_i,
  input  logic [NCORE-1:0]  lrst_pin_i,
  input  logic [NCORE-1:0]  lrst_ctl_i,
  input  logic [NCORE-1:0]  lrst_psc_i,
  input  logic              reg_wr_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic              reg_wdata_i,
  output logic [MODE_W-1:0] reg_rdata_o,
  output logic              dev_start_o,
  output logic [MODE_W-1:0] dev_mode_o,
  output logic [NCORE-1:0]  core_start_o,
  output logic [NCORE-1:0]  core_host_o
);

  logic             srst_n;
  logic             dev_rst;
  dev_cause_t       cause;
  logic [NCORE-1:0] core_mode;
  logic             wr_ok;

  assign cause = '{por: por_i, warm: warm_i, sys: sys_i};
  assign wr_ok = reg_wr_i & ~dev_rst;

  rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  dev_mode_unit #(.MODE_W(MODE_W)) u_dev (
    .clk       (clk),
    .rst_n     (srst_n),
    .cause_i   (cause),
    .strap_i   (strap_i),
    .dev_rst_o (dev_rst),
    .mode_o    (dev_mode_o),
    .start_o   (dev_start_o)
  );

  core_mode_regs #(.NCORE(NCORE), .ADDR_W(ADDR_W), .MODE_W(MODE_W)) u_regs (
    .clk       (clk),
    .rst_n     (srst_n),
    .dev_rst_i (dev_rst),
    .wr_i      (wr_ok),
    .addr_i    (reg_addr_i),
    .wdata_i   (reg_wdata_i),
    .stat_i    (dev_mode_o),
    .mode_o    (core_mode),
    .rdata_o   (reg_rdata_o)
  );

  for (genvar gc = 0; gc < NCORE; gc++) begin : g_core
    core_boot_ctl u_ctl (
      .clk       (clk),
      .rst_n     (srst_n),
      .dev_rst_i (dev_rst),
      .lrst_i    (lrst_pin_i[gc] | lrst_ctl_i[gc] | lrst_psc_i[gc]),
      .mode_i    (core_mode[gc]),
      .start_o   (core_start_o[gc]),
      .host_o    (core_host_o[gc])
    );
  end

  AST_NO_WR_IN_DEVRST: assert property (@(posedge clk) disable iff (!srst_n)
    (dev_rst && !$past(dev_rst)) |=> (core_mode == '0)); // R6

endmodule

// File: tb/sim_boot_mode_sel.sv
module sim_boot_mode_sel;

  localparam int NCORE = 6;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] strap_i;
  logic       por_i, warm_i, sys_i;
  logic [5:0] lrst_pin_i, lrst_ctl_i, lrst_psc_i;
  logic       reg_wr_i;
  logic [2:0] reg_addr_i;
  logic       reg_wdata_i;
  logic [3:0] reg_rdata_o;
  logic       dev_start_o;
  logic [3:0] dev_mode_o;
  logic [5:0] core_start_o, core_host_o;

  int compared = 0;
  int mismatched = 0;

  always #2 clk = ~clk;

  boot_mode_sel u0 (
    .clk(clk), .rst_n(rst_n), .strap_i(strap_i),
    .por_i(por_i), .warm_i(warm_i), .sys_i(sys_i),
    .lrst_pin_i(lrst_pin_i), .lrst_ctl_i(lrst_ctl_i), .lrst_psc_i(lrst_psc_i),
    .reg_wr_i(reg_wr_i), .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i),
    .reg_rdata_o(reg_rdata_o), .dev_start_o(dev_start_o), .dev_mode_o(dev_mode_o),
    .core_start_o(core_start_o), .core_host_o(core_host_o)
  );

  // vector fields: [5:3] core, [2] write data, [1:0] source (0 pin, 1 ctl, 2 psc)
  localparam logic [5:0] VEC [0:5] = '{
    {3'd0, 1'b1, 2'd0}, {3'd1, 1'b0, 2'd1}, {3'd2, 1'b1, 2'd2},
    {3'd3, 1'b1, 2'd0}, {3'd4, 1'b0, 2'd2}, {3'd5, 1'b1, 2'd1}
  };

  task automatic chk(input string tag, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic rd(input int a, output int d);
    reg_addr_i = 3'(a);
    #0.5;
    d = int'(reg_rdata_o);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  task automatic set_src(input int c, input int s, input logic v);
    case (s)
      0: lrst_pin_i[c] = v;
      1: lrst_ctl_i[c] = v;
      default: lrst_psc_i[c] = v;
    endcase
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    int d;
    rst_n = 1'b0; strap_i = 4'h0; por_i = 0; warm_i = 0; sys_i = 0;
    lrst_pin_i = '0; lrst_ctl_i = '0; lrst_psc_i = '0;
    reg_wr_i = 0; reg_addr_i = 3'd6; reg_wdata_i = 0;
    repeat (3) step();
    rst_n = 1'b1;
    repeat (3) step();

    // R1 reset state
    chk("R1 dev_start", dev_start_o, 0);
    chk("R1 dev_mode", dev_mode_o, 0);
    chk("R1 core_start", core_start_o, 0);
    chk("R1 core_host", core_host_o, 0);
    rd(6, d); chk("R1 stat read", d, 0);

    // R2 power-on latches strap; last asserted edge wins
    strap_i = 4'hA; por_i = 1; step();
    chk("R2 por load", dev_mode_o, 4'hA);
    strap_i = 4'h5; step();
    por_i = 0; strap_i = 4'hF; step();
    chk("R4 dev_start after por", dev_start_o, 1);
    chk("R2 por mode", dev_mode_o, 4'h5);
    step();
    chk("R4 dev_start one cycle", dev_start_o, 0);
    rd(6, d); chk("R2 stat read", d, 4'h5);

    // R2 warm reset
    strap_i = 4'h3; warm_i = 1; step();
    warm_i = 0; strap_i = 4'h0; step();
    chk("R2 warm mode", dev_mode_o, 4'h3);
    chk("R4 dev_start after warm", dev_start_o, 1);
    step();

    // R3 system reset ignores strap
    strap_i = 4'hC; sys_i = 1; step();
    chk("R4 no dev_start during sys", dev_start_o, 0);
    strap_i = 4'h9; step();
    sys_i = 0; step();
    chk("R4 dev_start after sys", dev_start_o, 1);
    chk("R3 sys keeps mode", dev_mode_o, 4'h3);
    step();

    // R5 / R8 table walk
    for (int v = 0; v < 6; v++) begin
      int c, s;
      logic w;
      c = int'(VEC[v][5:3]); w = VEC[v][2]; s = int'(VEC[v][1:0]);
      reg_wr_i = 1; reg_addr_i = 3'(c); reg_wdata_i = w; step();
      reg_wr_i = 0;
      rd(c, d); chk("R5 readback", d, int'(w));
      set_src(c, s, 1'b1); step();
      chk("R8 no pulse while held", core_start_o, 0);
      set_src(c, s, 1'b0); step();
      chk("R8 start pulse", core_start_o, 1 << c);
      chk("R8 host value", int'(core_host_o[c]), int'(w));
      step();
      chk("R8 pulse one cycle", core_start_o, 0);
    end
    chk("R8 host vector", core_host_o, 6'b101101);

    // R7 device reset clears core registers
    sys_i = 1; step(); sys_i = 0; step(); step();
    for (int c = 0; c < NCORE; c++) begin
      rd(c, d); chk("R7 cleared", d, 0);
    end

    // R6 write ignored during device reset, and to status address
    sys_i = 1; reg_wr_i = 1; reg_addr_i = 3'd0; reg_wdata_i = 1; step();
    sys_i = 0; reg_wr_i = 0; step();
    rd(0, d); chk("R6 write in reset ignored", d, 0);
    reg_wr_i = 1; reg_addr_i = 3'd6; reg_wdata_i = 1; step();
    reg_addr_i = 3'd7; step();
    reg_wr_i = 0;
    rd(6, d); chk("R6 stat write ignored", d, 4'h3);
    for (int c = 0; c < NCORE; c++) begin
      rd(c, d); chk("R6 no core touched", d, 0);
    end

    // R9 device reset beats overlapping local reset
    reg_wr_i = 1; reg_addr_i = 3'd1; reg_wdata_i = 1; step();
    reg_wr_i = 0;
    lrst_ctl_i[1] = 1; por_i = 1; strap_i = 4'h3; step(); step();
    lrst_ctl_i[1] = 0; por_i = 0; step();
    chk("R9 dev_start", dev_start_o, 1);
    chk("R9 no core pulse", core_start_o, 0);
    step();
    chk("R9 still no core pulse", core_start_o, 0);
    rd(1, d); chk("R7 por cleared core1", d, 0);

    // R10 write coincides with release
    reg_wr_i = 1; reg_addr_i = 3'd2; reg_wdata_i = 1; step();
    reg_wr_i = 0; lrst_pin_i[2] = 1; step();
    lrst_pin_i[2] = 0; reg_wr_i = 1; reg_addr_i = 3'd2; reg_wdata_i = 0; step();
    reg_wr_i = 0;
    chk("R10 pulse", core_start_o, 6'b000100);
    chk("R10 old value used", int'(core_host_o[2]), 1);
    step();
    rd(2, d); chk("R10 new value stored", d, 0);

    summary();
    $finish;
  end

endmodule